// File: doc/BRIEF.md
# Machine-Cycle Major-State Sequencer

This block is the control sequencer of a 12-bit processor. It walks the processor through its major states: instruction fetch, indirect-address defer, operand execute, and a self-repeating extended-arithmetic state. Every machine cycle is split into a fixed number of clock phases. A phase counter runs inside each cycle, and the major state may change only on the last phase. The datapath around it reads the state and phase outputs to pace its own register transfers.

After each fetch, the sequencer decodes the instruction word to pick the next cycle. Memory-reference words with the indirect bit set pass through defer. Words that need an operand run an execute cycle. Extended-arithmetic words enter the looping state, and the datapath keeps that state going through a loop-request input for as many passes as the operation needs. Front-panel controls can stop the machine at a cycle boundary. The sequencer keeps the cycle it would have run next, and it resumes that cycle on a continue or trigger pulse. Step mode stops it again after every machine cycle.

Top module: `cyc_sequencer`

## Requirements
- R1: While reset is low and on the first cycle after it, major_state is 0 (fetch) and phase is 0. The major_state encoding is: fetch 0, defer 1, execute 2, arithmetic loop 3, halted 4.
- R2: In every state other than halted, phase counts 0, 1, ..., PHASES-1 and then wraps to 0. major_state changes only on the clock edge at which phase equals PHASES-1.
- R3: At the end of fetch, an instruction with opcode instr[11:9] of 5 or less and indirect bit instr[8] set leads to defer.
- R4: At the end of fetch, a direct instruction with opcode 0 to 4 leads to execute. A direct opcode 5, or opcode 6 or 7 that is not a looping arithmetic word, returns to fetch.
- R5: The instruction is captured at the end of fetch. Defer leads to fetch when the captured opcode is 5 and to execute otherwise. Execute always leads to fetch.
- R6: An arithmetic word (opcode 7, instr[8]=1, instr[0]=1) with a nonzero function field instr[3:1] leads from fetch to the arithmetic-loop state. Function 0 returns to fetch. When arith_mode is 1, function 1 also returns to fetch.
- R7: At the end of an arithmetic-loop cycle, the state re-enters itself if arith_loop is 1 and goes to fetch if it is 0. arith_loop has no effect in other phases.
- R8: If halt_req is 1 at a cycle boundary, the next state is halted (4) in place of the computed successor. phase stays 0 while halted.
- R9: While halted, a cont_pulse or panel_trig moves the sequencer to the saved successor with phase 0 on the next edge. Without a pulse it stays halted.
- R10: With step_mode set, every machine cycle ends in halted, so each pulse advances exactly one machine cycle.
- R11: cont_pulse and panel_trig have no effect while the sequencer is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | WORD_W | Instruction word, decoded at the end of fetch |
| arith_mode | input | 1 | Extended-arithmetic mode bit |
| arith_loop | input | 1 | Request to repeat the arithmetic-loop state |
| halt_req | input | 1 | Stop at the next cycle boundary |
| step_mode | input | 1 | Stop after every machine cycle |
| cont_pulse | input | 1 | Continue pulse |
| panel_trig | input | 1 | Front-panel trigger pulse |
| major_state | output | 3 | Current major state |
| phase | output | PH_W | Clock phase within the current machine cycle |

## Verification
The hardest case to reach is a halt that lands in the middle of a run of arithmetic-loop passes. The saved successor must then be the loop state itself, and the machine must resume into it and continue looping. Directed stimulus sets arith_loop, issues an arithmetic word, raises halt_req during the second pass, and resumes with a continue pulse while arith_loop is still high. Long random runs then mix random instruction words with sparse halt, step and pulse activity. An independent model in the bench predicts every cycle.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_FETCH  = 3'd0,
        SEQ_DEFER  = 3'd1,
        SEQ_EXEC   = 3'd2,
        SEQ_ARITH  = 3'd3,
        SEQ_HALTED = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic defer;     // indirect memory reference
        logic operand;   // needs an execute cycle
        logic jump;      // memory-reference jump
        logic loop_op;   // enters the arithmetic-loop state
    } seq_dec_t;

endpackage

// File: rtl/cyc_phase_ctr.sv
module cyc_phase_ctr #(
    parameter int PHASES = 5,
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run && (phase_q != LAST_PH)) begin
            phase_q <= phase_q + PH_W'(1);
        end else begin
            phase_q <= '0;
        end
    end

    assign phase = phase_q;
    assign last  = run && (phase_q == LAST_PH);
endmodule

// File: rtl/cyc_instr_decode.sv
module cyc_instr_decode
    import cyc_seq_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] word,
    input  logic              arith_mode,
    output seq_dec_t          dec
);
    localparam int OPC_LSB = WORD_W - 3;
    localparam int IND_BIT = WORD_W - 4;
    localparam logic [2:0] OPC_JMP = 3'd5;
    localparam logic [2:0] OPC_OPR = 3'd7;

    logic [2:0] opc;
    logic       ind;
    logic [2:0] func;
    logic       mem_ref;
    logic       arith_word;

    always_comb begin
        opc        = word[OPC_LSB +: 3];
        ind        = word[IND_BIT];
        func       = word[3:1];
        mem_ref    = (opc <= OPC_JMP);
        arith_word = (opc == OPC_OPR) && ind && word[0];

        dec.defer   = mem_ref && ind;
        dec.operand = (opc < OPC_JMP);
        dec.jump    = (opc == OPC_JMP);
        dec.loop_op = arith_word && (func != 3'd0)
                      && !(arith_mode && (func == 3'd1));
    end
endmodule

// File: rtl/cyc_next_state.sv
module cyc_next_state
    import cyc_seq_pkg::*;
(
    input  seq_state_e cur,
    input  seq_dec_t   fetch_dec,
    input  seq_dec_t   held_dec,
    input  logic       arith_loop,
    output seq_state_e succ
);
    always_comb begin
        unique case (cur)
            SEQ_FETCH: begin
                if (fetch_dec.defer)        succ = SEQ_DEFER;
                else if (fetch_dec.operand) succ = SEQ_EXEC;
                else if (fetch_dec.loop_op) succ = SEQ_ARITH;
                else                        succ = SEQ_FETCH;
            end
            SEQ_DEFER:  succ = held_dec.jump ? SEQ_FETCH : SEQ_EXEC;
            SEQ_EXEC:   succ = SEQ_FETCH;
            SEQ_ARITH:  succ = arith_loop ? SEQ_ARITH : SEQ_FETCH;
            SEQ_HALTED: succ = SEQ_FETCH;
            default:    succ = SEQ_FETCH;
        endcase
    end
endmodule

// File: rtl/cyc_sequencer.sv
module cyc_sequencer
    import cyc_seq_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int PHASES = 5,
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr,
    input  logic              arith_mode,
    input  logic              arith_loop,
    input  logic              halt_req,
    input  logic              step_mode,
    input  logic              cont_pulse,
    input  logic              panel_trig,
    output logic [2:0]        major_state,
    output logic [PH_W-1:0]   phase
);
    seq_state_e        state_q;
    seq_state_e        resume_q;
    seq_state_e        succ;
    logic [WORD_W-1:0] ir_q;
    seq_dec_t          fetch_dec;
    seq_dec_t          held_dec;
    logic              run;
    logic              boundary;
    logic              stop_here;
    logic              go;

    assign run       = (state_q != SEQ_HALTED);
    assign stop_here = halt_req || step_mode;
    assign go        = cont_pulse || panel_trig;

    cyc_phase_ctr #(.PHASES(PHASES)) phase_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .phase (phase),
        .last  (boundary)
    );

    cyc_instr_decode #(.WORD_W(WORD_W)) fetch_dec_i (
        .word       (instr),
        .arith_mode (arith_mode),
        .dec        (fetch_dec)
    );

    cyc_instr_decode #(.WORD_W(WORD_W)) held_dec_i (
        .word       (ir_q),
        .arith_mode (arith_mode),
        .dec        (held_dec)
    );

    cyc_next_state next_i (
        .cur        (state_q),
        .fetch_dec  (fetch_dec),
        .held_dec   (held_dec),
        .arith_loop (arith_loop),
        .succ       (succ)
    );

    // state register, saved successor and captured instruction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SEQ_FETCH;
            resume_q <= SEQ_FETCH;
            ir_q     <= '0;
        end else begin
            unique case (state_q)
                SEQ_HALTED: begin
                    if (go) state_q <= resume_q;
                end
                SEQ_FETCH, SEQ_DEFER, SEQ_EXEC, SEQ_ARITH: begin
                    if (boundary) begin
                        if (stop_here) begin
                            state_q  <= SEQ_HALTED;
                            resume_q <= succ;
                        end else begin
                            state_q <= succ;
                        end
                        if (state_q == SEQ_FETCH) ir_q <= instr;
                    end
                end
                default: state_q <= SEQ_FETCH;
            endcase
        end
    end

    // outputs
    always_comb begin
        major_state = state_q;
    end
endmodule

// File: rtl/cyc_sequencer_chk.sv
module cyc_sequencer_chk #(
    parameter int PHASES = 5,
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arith_loop,
    input logic            halt_req,
    input logic            step_mode,
    input logic            cont_pulse,
    input logic            panel_trig,
    input logic [2:0]      major_state,
    input logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
    localparam logic [2:0] S_FETCH = 3'd0;
    localparam logic [2:0] S_EXEC  = 3'd2;
    localparam logic [2:0] S_ARITH = 3'd3;
    localparam logic [2:0] S_HALT  = 3'd4;

    assert_change_at_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(major_state) != S_HALT && major_state != $past(major_state))
        |-> $past(phase) == LAST_PH);

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state != S_HALT && phase != LAST_PH)
        |=> phase == $past(phase) + PH_W'(1));

    assert_exec_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state == S_EXEC && phase == LAST_PH && !halt_req && !step_mode)
        |=> major_state == S_FETCH);

    assert_loop_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state == S_ARITH && phase == LAST_PH && arith_loop && !halt_req && !step_mode)
        |=> major_state == S_ARITH);

    assert_halt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state != S_HALT && phase == LAST_PH && halt_req)
        |=> major_state == S_HALT);

    assert_halt_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state == S_HALT) |-> phase == '0);

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state == S_HALT && !cont_pulse && !panel_trig)
        |=> major_state == S_HALT);

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (major_state == S_HALT && (cont_pulse || panel_trig))
        |=> (major_state != S_HALT && phase == '0));
endmodule

bind cyc_sequencer cyc_sequencer_chk #(.PHASES(PHASES)) chk_i (.*);

// File: tb/cyc_sequencer_tb.sv
module cyc_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PHASES     = 5;
    localparam int PH_W       = $clog2(PHASES);
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] instr = '0;
    logic arith_mode = 1'b0, arith_loop = 1'b0, halt_req = 1'b0, step_mode = 1'b0;
    logic cont_pulse = 1'b0, panel_trig = 1'b0;
    logic [2:0] major_state;
    logic [PH_W-1:0] phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [2:0] m_state = 3'd0, m_resume = 3'd0;
    int         m_phase = 0;
    logic [11:0] m_ir = '0;
    string      m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_sequencer #(.WORD_W(12), .PHASES(PHASES)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .arith_mode(arith_mode),
        .arith_loop(arith_loop), .halt_req(halt_req), .step_mode(step_mode),
        .cont_pulse(cont_pulse), .panel_trig(panel_trig),
        .major_state(major_state), .phase(phase)
    );

    // successor after fetch (R3, R4, R6)
    function automatic logic [2:0] fetch_succ(logic [11:0] w, logic mode, output string tag);
        logic [2:0] opc = w[11:9];
        logic [2:0] fn = w[3:1];
        if (opc <= 3'd5 && w[8]) begin tag = "R3"; return 3'd1; end
        if (opc <= 3'd4) begin tag = "R4"; return 3'd2; end
        if (opc == 3'd7 && w[8] && w[0]) begin
            tag = "R6";
            if (fn == 3'd0 || (mode && fn == 3'd1)) return 3'd0;
            return 3'd3;
        end
        tag = "R4";
        return 3'd0;
    endfunction

    function automatic logic [2:0] cycle_succ(output string tag);
        case (m_state)
            3'd0: return fetch_succ(instr, arith_mode, tag);
            3'd1: begin tag = "R5"; return (m_ir[11:9] == 3'd5) ? 3'd0 : 3'd2; end
            3'd2: begin tag = "R5"; return 3'd0; end
            default: begin tag = "R7"; return arith_loop ? 3'd3 : 3'd0; end
        endcase
    endfunction

    task automatic model_step();
        string t;
        logic [2:0] nxt;
        if (m_state == 3'd4) begin
            if (cont_pulse || panel_trig) begin m_state = m_resume; m_tag = "R9"; end
            else m_tag = "R9";
            m_phase = 0;
        end else if (m_phase != PHASES - 1) begin
            m_phase++;
            m_tag = (cont_pulse || panel_trig) ? "R11" : (arith_loop ? "R7" : "R2");
        end else begin
            nxt = cycle_succ(t);
            if (m_state == 3'd0) m_ir = instr;
            m_phase = 0;
            if (halt_req || step_mode) begin
                m_resume = nxt;
                m_state  = 3'd4;
                m_tag    = step_mode ? "R10" : "R8";
            end else begin
                m_state = nxt;
                m_tag   = (cont_pulse || panel_trig) ? "R11" : t;
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (major_state !== m_state || int'(phase) != m_phase) begin
            errors++;
            $display("FAIL %s: state=%0d phase=%0d expected state=%0d phase=%0d",
                     tag, major_state, phase, m_state, m_phase);
        end
    endtask

    // advance one clock with the inputs currently driven
    task automatic tick();
        model_step();
        @(negedge clk);
        compare(m_tag);
        cont_pulse = 1'b0;
        panel_trig = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        void'($urandom(32'h1c3a_5e07));
        // R1: reset state
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        m_phase = 1;
        compare("R1");

        // R3/R5: indirect operand reference, then indirect jump
        instr = 12'o1400;
        ticks(PHASES * 3 - 1);
        instr = 12'o5400;
        ticks(PHASES * 2);
        // R4: direct operand, direct jump, plain operate
        instr = 12'o2000; ticks(PHASES * 2);
        instr = 12'o5000; ticks(PHASES);
        instr = 12'o7200; ticks(PHASES);
        // R6: arithmetic function 1 in both modes, function 0
        arith_mode = 1'b1; instr = 12'o7403; ticks(PHASES);
        arith_mode = 1'b0; instr = 12'o7401; ticks(PHASES);
        instr = 12'o7403; ticks(PHASES);
        // R7: three loop passes
        arith_loop = 1'b1; instr = 12'o7411; ticks(PHASES * 3);
        arith_loop = 1'b0; ticks(PHASES * 2);
        // R8/R9: halt in second loop pass, resume into loop
        arith_loop = 1'b1; instr = 12'o7413; ticks(PHASES + 2);
        halt_req = 1'b1; ticks(PHASES);
        halt_req = 1'b0; ticks(4);
        cont_pulse = 1'b1; tick();
        ticks(PHASES);
        arith_loop = 1'b0; ticks(PHASES * 2);
        // R10: step with trigger pulses; R11 pulses while running
        step_mode = 1'b1; instr = 12'o1400; ticks(PHASES + 1);
        for (int k = 0; k < 4; k++) begin
            panel_trig = 1'b1; tick();
            ticks(PHASES + 2);
        end
        step_mode = 1'b0;
        cont_pulse = 1'b1; tick();
        ticks(2);
        cont_pulse = 1'b1; tick();
        ticks(PHASES * 2);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 3) == 0) instr = 12'($urandom);
            if ($urandom_range(0, 7) == 0) instr = {3'd7, 1'b1, 4'($urandom), 3'($urandom), 1'b1};
            arith_loop = ($urandom_range(0, 2) != 0);
            arith_mode = ($urandom_range(0, 9) == 0) ? ~arith_mode : arith_mode;
            halt_req   = ($urandom_range(0, 40) == 0);
            if ($urandom_range(0, 300) == 0) step_mode = ~step_mode;
            cont_pulse = ($urandom_range(0, 5) == 0);
            panel_trig = ($urandom_range(0, 9) == 0);
            tick();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule